// File: doc/BRIEF.md
# Selectable Sample Clock Prescaler

This block produces the sampling-rate timing for a voice recorder. It generates two single-cycle enables in the system clock domain. The first is an oversampling strobe. The second is the sample strobe, which fires once for every 128 oversampling strobes. The oversampling strobe comes from one of two sources. One is a free-running external clock, divided by a programmable integer ratio. The other is an internal rate generator with four fixed settings, each modelled as a fixed division of the system clock.

The configuration is loaded from the 10-bit parameter of a power-up command. Bits [1:0] pick the internal rate and bits [9:2] hold the external divide ratio. An activity detector watches the synchronized external clock and declares it present on every rising edge. It declares the clock absent after a programmable number of system cycles with no edge. While a clock is present the block uses it, and otherwise it falls back to the internal generator.

Moving onto the external source happens only at a sample-strobe boundary or at a configuration load, so no sample period is cut short. Losing the external clock while it is in use switches back to the internal generator at once.

Top module: `sample_clock_prescaler`

## Requirements
- R1: After reset, `overStb`, `sampleStb` and `extSel` are 0. The block runs from the internal source at rate code 00, which is 6.4 kHz with an oversampling period of `DIV_6K4` (default 10) system cycles.
- R2: The internal rate code in `cfgParam[1:0]` sets the oversampling period. Code 00 (6.4 kHz) uses `DIV_6K4`=10 cycles, code 01 (4.0 kHz) uses `DIV_4K0`=16, code 10 (8.0 kHz) uses `DIV_8K0`=8 and code 11 (5.3 kHz) uses `DIV_5K3`=12. `overStb` is never high in two consecutive cycles.
- R3: With the external source selected, `overStb` fires once per N rising edges of `extClk`. N comes from `cfgParam[9:2]`. Edges are seen through a two-stage synchronizer, so for example the code 00001000 gives N = 8.
- R4: The ratio code 00000000 is treated as N = 256.
- R5: The ratio code 00000010 is not allowed and is coerced to N = 3.
- R6: `sampleStb` fires on every 128th `overStb` and only in a cycle where `overStb` is also high. The sample rate is therefore the source rate divided by N and then by 128.
- R7: The external clock is declared absent after `TIMEOUT` (default 64) system cycles with no synchronized rising edge. If the external source is in use at that moment, `extSel` drops to 0 at once and the internal generator takes over.
- R8: When the external clock becomes present while the internal source is in use, `extSel` rises only in the cycle after a `sampleStb` pulse, or right after a `cfgLoad`.
- R9: A `cfgLoad` pulse latches `cfgParam`. It also restarts both prescalers and the 128-count, and it picks the source from the current presence state. From then on the outputs follow the behaviour above cycle for cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extClk | input | 1 | External sampling clock, asynchronous, may be idle |
| cfgLoad | input | 1 | One-cycle pulse that loads `cfgParam` (power-up command) |
| cfgParam | input | 10 | [9:2] external ratio code, [1:0] internal rate code |
| overStb | output | 1 | Oversampling strobe, 128 per sample |
| sampleStb | output | 1 | Sample strobe |
| extSel | output | 1 | 1 while the external source drives the strobes |

## Verification
The internal generator is run with each of the four rate codes. The measured strobe spacing shows whether each code maps to its own divisor and in the stated order. The external clock is run at a fixed period with the ratio codes 8, 1, 0 and 2. Code 8 confirms the plain ratio, code 1 confirms the smallest ratio, and codes 0 and 2 show the two coercions apart from the plain mapping. The external clock is also started and stopped around sample boundaries. This shows whether a source change is deferred to the boundary or, when the clock is lost, taken at once. A behavioural reference model compared on every cycle covers the restart behaviour after each load.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int CFG_W = 10;
  localparam int RATIO_W = 9;

  typedef struct packed {
    logic restart;
    logic srcExt;
  } scp_ctl_t;
endpackage

// File: rtl/scp_ctrl.sv
module scp_ctrl
  import scp_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgLoad,
  input  logic [CFG_W-1:0]     cfgParam,
  input  logic                 extEdge,
  input  logic                 sampleStb,
  output scp_ctl_t             ctl,
  output logic [1:0]           rateCode,
  output logic [RATIO_W-1:0]   nRatio
);
  localparam int IDLE_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(TIMEOUT - 1);

  logic [IDLE_W-1:0]  idleCnt;
  logic               extPresent;
  logic               srcExt;
  logic               switchNow;
  logic               restart;
  logic [RATIO_W-1:0] ratioDecoded;

  // Ratio code decode: 0 means 256, 2 is coerced to 3
  always_comb begin
    if (cfgParam[9:2] == 8'd0)
      ratioDecoded = RATIO_W'(256);
    else if (cfgParam[9:2] == 8'd2)
      ratioDecoded = RATIO_W'(3);
    else
      ratioDecoded = {1'b0, cfgParam[9:2]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateCode <= 2'b00;
      nRatio   <= RATIO_W'(1);
    end else if (cfgLoad) begin
      rateCode <= cfgParam[1:0];
      nRatio   <= ratioDecoded;
    end
  end

  // Activity detector on the synchronized external clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt    <= '0;
      extPresent <= 1'b0;
    end else if (extEdge) begin
      idleCnt    <= '0;
      extPresent <= 1'b1;
    end else if (idleCnt == IDLE_LAST) begin
      extPresent <= 1'b0;
    end else begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  // Source switch: at a sample boundary, or at once when the running external clock is lost
  always_comb begin
    switchNow = (srcExt != extPresent) && (sampleStb || (srcExt && !extPresent));
    restart   = cfgLoad || switchNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      srcExt <= 1'b0;
    else if (restart)
      srcExt <= extPresent;
  end

  assign ctl.restart = restart;
  assign ctl.srcExt  = srcExt;

  p_src_only_on_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(srcExt) |-> $past(restart));

  p_ext_loss_immediate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (srcExt && !extPresent) |=> !srcExt);

  p_absent_after_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(extPresent) |-> ($past(idleCnt) == IDLE_LAST));

  p_ratio_legal_r5: assert property (@(posedge clk) disable iff (!rstN)
    (nRatio != RATIO_W'(2)) && (nRatio != '0));
endmodule

// File: rtl/scp_datapath.sv
module scp_datapath
  import scp_pkg::*;
#(
  parameter int DIV_6K4    = 10,
  parameter int DIV_4K0    = 16,
  parameter int DIV_8K0    = 8,
  parameter int DIV_5K3    = 12,
  parameter int OVERSAMPLE = 128,
  parameter int SYNC_LEN   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               extClk,
  input  scp_ctl_t           ctl,
  input  logic [1:0]         rateCode,
  input  logic [RATIO_W-1:0] nRatio,
  output logic               extEdge,
  output logic               overStb,
  output logic               sampleStb
);
  localparam int DIV_MAX_A = (DIV_6K4 > DIV_4K0) ? DIV_6K4 : DIV_4K0;
  localparam int DIV_MAX_B = (DIV_8K0 > DIV_5K3) ? DIV_8K0 : DIV_5K3;
  localparam int DIV_MAX   = (DIV_MAX_A > DIV_MAX_B) ? DIV_MAX_A : DIV_MAX_B;
  localparam int INT_W     = $clog2(DIV_MAX);
  localparam int SMP_W     = $clog2(OVERSAMPLE);
  localparam logic [SMP_W-1:0] SMP_LAST = SMP_W'(OVERSAMPLE - 1);

  logic [SYNC_LEN:0]   syncQ;
  logic [INT_W-1:0]    intCnt;
  logic [INT_W-1:0]    intLast;
  logic [RATIO_W-2:0]  extCnt;
  logic [SMP_W-1:0]    smpCnt;
  logic                intTick;
  logic                extTick;
  logic                overRaw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_LEN-1:0], extClk};
  end

  assign extEdge = syncQ[SYNC_LEN-1] & ~syncQ[SYNC_LEN];

  always_comb begin
    case (rateCode)
      2'b00:   intLast = INT_W'(DIV_6K4 - 1);
      2'b01:   intLast = INT_W'(DIV_4K0 - 1);
      2'b10:   intLast = INT_W'(DIV_8K0 - 1);
      default: intLast = INT_W'(DIV_5K3 - 1);
    endcase
  end

  assign intTick = (intCnt == intLast);
  assign extTick = extEdge && ({1'b0, extCnt} == (nRatio - RATIO_W'(1)));
  assign overRaw = ctl.srcExt ? extTick : intTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            intCnt <= '0;
    else if (ctl.restart) intCnt <= '0;
    else if (intTick)     intCnt <= '0;
    else                  intCnt <= intCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            extCnt <= '0;
    else if (ctl.restart) extCnt <= '0;
    else if (extTick)     extCnt <= '0;
    else if (extEdge)     extCnt <= extCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smpCnt    <= '0;
      overStb   <= 1'b0;
      sampleStb <= 1'b0;
    end else begin
      overStb   <= overRaw && !ctl.restart;
      sampleStb <= overRaw && !ctl.restart && (smpCnt == SMP_LAST);
      if (ctl.restart)
        smpCnt <= '0;
      else if (overRaw)
        smpCnt <= (smpCnt == SMP_LAST) ? '0 : smpCnt + 1'b1;
    end
  end

  p_smp_with_over_r6: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> overStb);

  p_over_spacing_r2: assert property (@(posedge clk) disable iff (!rstN)
    overStb |=> !overStb);
endmodule

// File: rtl/sample_clock_prescaler.sv
module sample_clock_prescaler
  import scp_pkg::*;
#(
  parameter int DIV_6K4    = 10,
  parameter int DIV_4K0    = 16,
  parameter int DIV_8K0    = 8,
  parameter int DIV_5K3    = 12,
  parameter int OVERSAMPLE = 128,
  parameter int TIMEOUT    = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extClk,
  input  logic       cfgLoad,
  input  logic [9:0] cfgParam,
  output logic       overStb,
  output logic       sampleStb,
  output logic       extSel
);
  scp_ctl_t           ctl;
  logic [1:0]         rateCode;
  logic [RATIO_W-1:0] nRatio;
  logic               extEdge;

  scp_ctrl #(.TIMEOUT(TIMEOUT)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgParam(cfgParam),
    .extEdge(extEdge), .sampleStb(sampleStb), .ctl(ctl),
    .rateCode(rateCode), .nRatio(nRatio)
  );

  scp_datapath #(
    .DIV_6K4(DIV_6K4), .DIV_4K0(DIV_4K0), .DIV_8K0(DIV_8K0), .DIV_5K3(DIV_5K3),
    .OVERSAMPLE(OVERSAMPLE), .SYNC_LEN(2)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .extClk(extClk), .ctl(ctl),
    .rateCode(rateCode), .nRatio(nRatio), .extEdge(extEdge),
    .overStb(overStb), .sampleStb(sampleStb)
  );

  assign extSel = ctl.srcExt;
endmodule

// File: tb/test_sample_clock_prescaler.sv
`timescale 1ns/1ps
module test_sample_clock_prescaler;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 64;
  localparam int OVS = 128;
  localparam int EXT_HALF = 2;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extClk = 1'b0;
  logic cfgLoad = 1'b0;
  logic [9:0] cfgParam = '0;
  logic overStb, sampleStb, extSel;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int lastOver = 0, overGap = 0, overSeen = 0;
  int lastSmp = 0, smpGap = 0, smpSeen = 0;
  bit extRun = 1'b0;
  int extPh = 0;
  bit finished = 1'b0;

  // reference model state
  int q1, q2, q3, idle, present, src, rate, nr, ic, ec, sc, mOver, mSmp;

  sample_clock_prescaler i_sample_clock_prescaler (
    .clk(clk), .rstN(rstN), .extClk(extClk), .cfgLoad(cfgLoad),
    .cfgParam(cfgParam), .overStb(overStb), .sampleStb(sampleStb), .extSel(extSel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int divOf(int code);
    case (code)
      0: return 10;
      1: return 16;
      2: return 8;
      default: return 12;
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q1 = 0; q2 = 0; q3 = 0; idle = 0; present = 0; src = 0;
      rate = 0; nr = 1; ic = 0; ec = 0; sc = 0; mOver = 0; mSmp = 0;
    end else begin
      int edgeSeen, rst, iT, eT, raw, nCode;
      int nPresent, nIdle, nSrc;
      edgeSeen = (q2 == 1 && q3 == 0);
      rst = cfgLoad || ((src != present) && (mSmp || (src && !present)));
      iT = (ic == divOf(rate) - 1);
      eT = edgeSeen && (ec == nr - 1);
      raw = src ? eT : iT;
      nPresent = present; nIdle = idle;
      if (edgeSeen) begin nPresent = 1; nIdle = 0; end
      else if (idle == TO - 1) nPresent = 0;
      else nIdle = idle + 1;
      nSrc = rst ? present : src;
      ic = rst ? 0 : (iT ? 0 : ic + 1);
      ec = rst ? 0 : (eT ? 0 : (edgeSeen ? ec + 1 : ec));
      mOver = raw && !rst;
      mSmp = raw && !rst && (sc == OVS - 1);
      if (rst) sc = 0;
      else if (raw) sc = (sc == OVS - 1) ? 0 : sc + 1;
      if (cfgLoad) begin
        rate = cfgParam[1:0];
        nCode = cfgParam[9:2];
        nr = (nCode == 0) ? 256 : ((nCode == 2) ? 3 : nCode);
      end
      present = nPresent; idle = nIdle; src = nSrc;
      q3 = q2; q2 = q1; q1 = extClk;
    end
  end

  // monitor, model comparison and external clock drive
  always @(negedge clk) begin
    if (!finished) begin
      cyc++;
      if (rstN) begin
        // R9: cycle-by-cycle agreement with the reference model
        check(overStb == mOver[0], "R9 overStb vs model", overStb, mOver);
        check(sampleStb == mSmp[0], "R9 sampleStb vs model", sampleStb, mSmp);
        check(extSel == src[0], "R9 extSel vs model", extSel, src);
      end
      if (overStb) begin overGap = cyc - lastOver; lastOver = cyc; overSeen++; end
      if (sampleStb) begin smpGap = cyc - lastSmp; lastSmp = cyc; smpSeen++; end
      if (extRun) begin
        extPh++;
        if (extPh == EXT_HALF) begin extPh = 0; extClk <= ~extClk; end
      end
      if (cyc > WATCHDOG) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic waitOver(int n);
    int target;
    target = overSeen + n;
    while (overSeen < target) tick(1);
  endtask

  task automatic waitSmp(int n);
    int target;
    target = smpSeen + n;
    while (smpSeen < target) tick(1);
  endtask

  task automatic load(logic [7:0] nCode, logic [1:0] rc);
    cfgParam = {nCode, rc};
    cfgLoad = 1'b1;
    tick(1);
    cfgLoad = 1'b0;
  endtask

  initial begin
    tick(3);
    check(overStb == 0 && sampleStb == 0 && extSel == 0, "R1 outputs in reset",
          {overStb, sampleStb, extSel}, 0);
    rstN = 1'b1;
    tick(1);
    check(extSel == 0, "R1 internal source after reset", extSel, 0);
    waitOver(3);
    check(overGap == 10, "R1 default 6.4k oversample period", overGap, 10);
    waitSmp(2);
    check(smpGap == 10 * OVS, "R6 sample period internal 6.4k", smpGap, 10 * OVS);

    // R2: each internal rate code
    for (int c = 1; c < 4; c++) begin
      load(8'd8, 2'(c));
      waitOver(3);
      check(overGap == divOf(c), "R2 internal rate code period", overGap, divOf(c));
    end

    // R8: presence alone does not switch before a sample boundary
    waitSmp(1);
    extRun = 1'b1;
    tick(30);
    check(extSel == 0, "R8 no switch before sample boundary", extSel, 0);
    waitSmp(1);
    tick(1);
    check(extSel == 1, "R8 switch right after sample boundary", extSel, 1);
    waitOver(3);
    check(overGap == 8 * 2 * EXT_HALF, "R3 external ratio N=8", overGap, 8 * 2 * EXT_HALF);
    waitSmp(2);
    check(smpGap == 8 * 2 * EXT_HALF * OVS, "R6 sample period external N=8",
          smpGap, 8 * 2 * EXT_HALF * OVS);

    // R7: losing the external clock
    extRun = 1'b0;
    tick(TO + 8);
    check(extSel == 0, "R7 fallback to internal on clock loss", extSel, 0);
    waitOver(3);
    check(overGap == 12, "R7 internal rate resumes", overGap, 12);

    // R4, R5 and N=1 with the clock running, switch at load
    extRun = 1'b1;
    tick(20);
    load(8'd1, 2'b00);
    check(extSel == 1, "R9 load selects present external clock", extSel, 1);
    waitOver(3);
    check(overGap == 2 * EXT_HALF, "R3 external ratio N=1", overGap, 2 * EXT_HALF);
    waitSmp(2);
    check(smpGap == 2 * EXT_HALF * OVS, "R6 sample period external N=1",
          smpGap, 2 * EXT_HALF * OVS);
    load(8'd2, 2'b00);
    waitOver(3);
    check(overGap == 3 * 2 * EXT_HALF, "R5 ratio code 2 acts as 3", overGap, 3 * 2 * EXT_HALF);
    load(8'd0, 2'b00);
    waitOver(3);
    check(overGap == 256 * 2 * EXT_HALF, "R4 ratio code 0 acts as 256",
          overGap, 256 * 2 * EXT_HALF);

    extRun = 1'b0;
    tick(TO + 8);
    check(extSel == 0, "R7 second clock loss", extSel, 0);
    waitOver(3);
    check(overGap == 10, "R2 code 00 after loss", overGap, 10);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule